// File: doc/BRIEF.md
# Display Controller Host Register Front End

This block sits between the host I/O bus and the display core of a VGA-compatible display controller. It decodes byte-wide I/O accesses and holds the registers the host programs directly. These are the miscellaneous output register, the CRTC index and its data file, and two extended registers that pick which 64 KB slice of a 512 KB frame buffer the host memory window reaches. It also answers a fixed two-byte adapter identity. Every address in the 0x3Bx or 0x3Dx ranges is folded onto the colour range when the colour-addressing bit is clear, so a monochrome-style program reaches the same CRTC.

The block produces three things for the rest of the controller. It drives a registered bank base, shared by reads and writes. It adds that base to the host window offset to form the frame buffer address. It raises a one-cycle pulse whenever a write alters a CRTC register that affects display timing, so that the timing logic can recompute.

Reads are combinational from the current register state and the presented address. Writes take effect at the rising clock edge on which `wr_en` is high.

Top module: `vga_host_regs`

## Requirements
- R1: After reset the miscellaneous output register reads 0x01 at port 0x3CC. All CRTC registers, the CRTC index, the bank register (0x2108), the extended register (0x210A), the bank base and the timing pulse are zero.
- R2: A write to port 0x3D4 keeps only bits 4:0 as the CRTC index. A read of 0x3D4 returns that index with bits 7:5 zero, and a read of 0x3D5 returns the CRTC register it selects.
- R3: While bit 0 of the miscellaneous output register is 0, any address whose bits 15:4 are 0x03B or 0x03D is XORed with 0x060 before decoding. So 0x3B4 and 0x3B5 reach the CRTC, and 0x3D4 and 0x3D5 are unmapped: writes there are ignored and reads return 0xFF.
- R4: While bit 7 of CRTC register 0x11 is 1, writes to CRTC registers 0x00 to 0x06 leave them unchanged and raise no timing pulse.
- R5: While bit 7 of CRTC register 0x11 is 1, a write to CRTC register 0x07 updates only bit 4. Bits 7:5 and 3:0 keep their old values.
- R6: `timing_chg` is high for exactly the one cycle after a CRTC data write that changes a register with index below 0x0E or above 0x10. A write that leaves the value unchanged, or that targets 0x0E to 0x10, gives no pulse.
- R7: When bits 2:0 of the mode register (port 0x2100, write-only) are below 4, the bank base is 0. Otherwise it is bits 2:0 of the bank register times 0x10000. Writing the mode register updates the base on the next cycle.
- R8: A write to 0x2108 always stores all 8 bits. It moves the bank base only while the stored mode is 4 or more.
- R9: Port 0x100 reads 0xFE and port 0x101 reads 0xE8. Ports 0x2108 and 0x210A read back their stored bytes. Port 0x3CC reads the miscellaneous output register, which is written at 0x3C2. Every other address reads 0xFF.
- R10: `fb_addr` equals `bank_base` plus the 16-bit `win_off`, as a 19-bit address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the presented address |
| addr | input | 16 | Host I/O address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the presented address |
| win_off | input | 16 | Offset inside the 64 KB host memory window |
| bank_base | output | 19 | Active bank base, shared by reads and writes |
| fb_addr | output | 19 | Frame buffer address |
| timing_chg | output | 1 | One-cycle pulse on a timing register change |

## Verification
A behavioural model in the bench tracks every register and is compared with the read data, the bank base, the frame address and the timing pulse on each clock.

Directed sequences come first:
- Rewriting a value tells a real change from a repeated one.
- Writes to index 0x0F separate the quiet range from the others.
- Locked writes to registers 3 and 7 expose the full and partial protection.
- Writing the bank register under low and high modes shows whether the stored byte and the active base diverge correctly.
- Clearing the colour bit checks that the mono ports reach the CRTC while the colour ports fall silent.

A long stretch of random accesses over all decoded and some undecoded ports then mixes these conditions with random window offsets.

// File: rtl/vga_host_pkg.sv
package vga_host_pkg;

    localparam int BYTE_W = 8;

    // I/O addresses (colour-range view)
    localparam int P_MISC_WR   = 16'h03C2;
    localparam int P_MISC_RD   = 16'h03CC;
    localparam int P_CRTC_IDX  = 16'h03D4;
    localparam int P_CRTC_DAT  = 16'h03D5;
    localparam int P_MODE      = 16'h2100;
    localparam int P_BANK      = 16'h2108;
    localparam int P_EXT       = 16'h210A;
    localparam int P_ID_LO     = 16'h0100;
    localparam int P_ID_HI     = 16'h0101;
    localparam int P_MONO_HI   = 12'h03B;
    localparam int P_COLOR_HI  = 12'h03D;
    localparam int P_FOLD      = 16'h0060;

    localparam logic [BYTE_W-1:0] ID_LO_VAL = 8'hFE;
    localparam logic [BYTE_W-1:0] ID_HI_VAL = 8'hE8;
    localparam logic [BYTE_W-1:0] OPEN_BUS  = 8'hFF;
    localparam logic [BYTE_W-1:0] MISC_RST  = 8'h01;

    // CRTC protection and timing classification
    localparam int PROT_REG     = 8'h11;
    localparam int PROT_BIT     = 7;
    localparam int LAST_LOCKED  = 6;
    localparam int PARTIAL_REG  = 7;
    localparam logic [BYTE_W-1:0] PARTIAL_MASK = 8'h10;
    localparam int QUIET_LO     = 8'h0E;
    localparam int QUIET_HI     = 8'h10;

    // bank mode field
    localparam int MODE_W       = 3;
    localparam int MODE_BANKED  = 4;

    typedef enum logic [3:0] {
        TGT_NONE,
        TGT_MISC_WR,
        TGT_MISC_RD,
        TGT_CRTC_IDX,
        TGT_CRTC_DAT,
        TGT_MODE,
        TGT_BANK,
        TGT_EXT,
        TGT_ID_LO,
        TGT_ID_HI
    } tgt_e;

endpackage

// File: rtl/vga_port_decode.sv
module vga_port_decode
    import vga_host_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              color_sel,
    output tgt_e              tgt
);

    logic [ADDR_W-1:0] eff;
    logic              in_fold_range;

    always_comb begin
        in_fold_range = (addr[ADDR_W-1:4] == (ADDR_W-4)'(P_MONO_HI)) ||
                        (addr[ADDR_W-1:4] == (ADDR_W-4)'(P_COLOR_HI));
        eff = addr;
        if (!color_sel && in_fold_range) begin
            eff = addr ^ ADDR_W'(P_FOLD);
        end

        if      (eff == ADDR_W'(P_MISC_WR))  tgt = TGT_MISC_WR;
        else if (eff == ADDR_W'(P_MISC_RD))  tgt = TGT_MISC_RD;
        else if (eff == ADDR_W'(P_CRTC_IDX)) tgt = TGT_CRTC_IDX;
        else if (eff == ADDR_W'(P_CRTC_DAT)) tgt = TGT_CRTC_DAT;
        else if (eff == ADDR_W'(P_MODE))     tgt = TGT_MODE;
        else if (eff == ADDR_W'(P_BANK))     tgt = TGT_BANK;
        else if (eff == ADDR_W'(P_EXT))      tgt = TGT_EXT;
        else if (eff == ADDR_W'(P_ID_LO))    tgt = TGT_ID_LO;
        else if (eff == ADDR_W'(P_ID_HI))    tgt = TGT_ID_HI;
        else                                 tgt = TGT_NONE;
    end

endmodule

// File: rtl/vga_crtc_file.sv
module vga_crtc_file
    import vga_host_pkg::*;
#(
    parameter int CIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_idx,
    input  logic              wr_dat,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CIDX_W-1:0] idx,
    output logic [BYTE_W-1:0] cur_val,
    output logic              chg
);

    localparam int CRTC_N = 1 << CIDX_W;

    typedef struct packed {
        logic [CIDX_W-1:0]                  idx;
        logic [CRTC_N-1:0][BYTE_W-1:0]      regs;
        logic                               chg;
    } crtc_st_t;

    crtc_st_t q, d;

    logic              locked;
    logic              blocked;
    logic              quiet;
    logic [BYTE_W-1:0] old_v;
    logic [BYTE_W-1:0] new_v;

    always_comb begin
        locked  = q.regs[CIDX_W'(PROT_REG)][PROT_BIT];
        blocked = locked && (q.idx <= CIDX_W'(LAST_LOCKED));
        quiet   = (q.idx >= CIDX_W'(QUIET_LO)) && (q.idx <= CIDX_W'(QUIET_HI));
        old_v   = q.regs[q.idx];
        if (locked && (q.idx == CIDX_W'(PARTIAL_REG))) begin
            new_v = (old_v & ~PARTIAL_MASK) | (wdata & PARTIAL_MASK);
        end else begin
            new_v = wdata;
        end

        d     = q;
        d.chg = 1'b0;
        if (wr_idx) begin
            d.idx = wdata[CIDX_W-1:0];
        end
        if (wr_dat && !blocked) begin
            d.regs[q.idx] = new_v;
            d.chg         = (new_v != old_v) && !quiet;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign idx     = q.idx;
    assign cur_val = q.regs[q.idx];
    assign chg     = q.chg;

    // R4: locked registers do not move and give no pulse
    a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && locked && q.idx <= CIDX_W'(LAST_LOCKED))
        |=> (q.regs == $past(q.regs)) && !q.chg);

    // R5: only bit 4 of register 7 may move under the lock
    a_r5_partial_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && locked && q.idx == CIDX_W'(PARTIAL_REG))
        |=> ((q.regs[CIDX_W'(PARTIAL_REG)] & ~PARTIAL_MASK) ==
             ($past(q.regs[CIDX_W'(PARTIAL_REG)]) & ~PARTIAL_MASK)));

    // R6: quiet-range writes give no pulse
    a_r6_quiet_range: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && q.idx >= CIDX_W'(QUIET_LO) && q.idx <= CIDX_W'(QUIET_HI))
        |=> !q.chg);

    // R6: a pulse only follows a data write
    a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        q.chg |-> $past(wr_dat));

endmodule

// File: rtl/vga_bank_sel.sv
module vga_bank_sel
    import vga_host_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int WIN_W  = 16,
    localparam int FB_W  = WIN_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mode,
    input  logic              wr_bank,
    input  logic              wr_ext,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] bank_byte,
    output logic [BYTE_W-1:0] ext_byte,
    output logic [FB_W-1:0]   base
);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [BYTE_W-1:0] bank;
        logic [BYTE_W-1:0] ext;
        logic [FB_W-1:0]   base;
    } bank_st_t;

    bank_st_t q, d;

    function automatic logic [FB_W-1:0] slice_base(input logic [BYTE_W-1:0] b);
        return {b[BANK_W-1:0], {WIN_W{1'b0}}};
    endfunction

    logic banked_q;
    logic banked_new;

    always_comb begin
        banked_q   = q.mode >= MODE_W'(MODE_BANKED);
        banked_new = wdata[MODE_W-1:0] >= MODE_W'(MODE_BANKED);

        d = q;
        if (wr_mode) begin
            d.mode = wdata[MODE_W-1:0];
            d.base = banked_new ? slice_base(q.bank) : '0;
        end
        if (wr_bank) begin
            d.bank = wdata;
            if (banked_q) begin
                d.base = slice_base(wdata);
            end
        end
        if (wr_ext) begin
            d.ext = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bank_byte = q.bank;
    assign ext_byte  = q.ext;
    assign base      = q.base;

    // R7: a low mode always leaves the base at zero
    a_r7_low_mode_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !banked_q |-> (q.base == '0));

    // R8: bank write under a low mode keeps the base
    a_r8_bank_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bank && !wr_mode && !banked_q) |=> $stable(q.base));

    // R8: bank write always lands in the stored byte
    a_r8_bank_stored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bank |=> (q.bank == $past(wdata)));

endmodule

// File: rtl/vga_host_regs.sv
module vga_host_regs
    import vga_host_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 16,
    parameter int BANK_W = 3,
    parameter int CIDX_W = 5,
    localparam int FB_W  = WIN_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic [WIN_W-1:0]  win_off,
    output logic [FB_W-1:0]   bank_base,
    output logic [FB_W-1:0]   fb_addr,
    output logic              timing_chg
);

    typedef struct packed {
        logic [BYTE_W-1:0] misc;
    } top_st_t;

    top_st_t q, d;

    tgt_e              tgt;
    logic [CIDX_W-1:0] crtc_idx;
    logic [BYTE_W-1:0] crtc_val;
    logic [BYTE_W-1:0] bank_byte;
    logic [BYTE_W-1:0] ext_byte;

    vga_port_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr      (addr),
        .color_sel (q.misc[0]),
        .tgt       (tgt)
    );

    vga_crtc_file #(.CIDX_W(CIDX_W)) u_crtc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_idx  (wr_en && (tgt == TGT_CRTC_IDX)),
        .wr_dat  (wr_en && (tgt == TGT_CRTC_DAT)),
        .wdata   (wdata),
        .idx     (crtc_idx),
        .cur_val (crtc_val),
        .chg     (timing_chg)
    );

    vga_bank_sel #(.BANK_W(BANK_W), .WIN_W(WIN_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mode   (wr_en && (tgt == TGT_MODE)),
        .wr_bank   (wr_en && (tgt == TGT_BANK)),
        .wr_ext    (wr_en && (tgt == TGT_EXT)),
        .wdata     (wdata),
        .bank_byte (bank_byte),
        .ext_byte  (ext_byte),
        .base      (bank_base)
    );

    always_comb begin
        d = q;
        if (wr_en && (tgt == TGT_MISC_WR)) begin
            d.misc = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{misc: MISC_RST};
        else        q <= d;
    end

    always_comb begin
        case (tgt)
            TGT_MISC_RD:  rdata = q.misc;
            TGT_CRTC_IDX: rdata = BYTE_W'(crtc_idx);
            TGT_CRTC_DAT: rdata = crtc_val;
            TGT_BANK:     rdata = bank_byte;
            TGT_EXT:      rdata = ext_byte;
            TGT_ID_LO:    rdata = ID_LO_VAL;
            TGT_ID_HI:    rdata = ID_HI_VAL;
            default:      rdata = OPEN_BUS;
        endcase
    end

    assign fb_addr = bank_base + FB_W'(win_off);

    // R3: with mono addressing, the colour index port is dead
    a_r3_mono_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !q.misc[0] && addr == ADDR_W'(P_CRTC_IDX)) |=> $stable(crtc_idx));

    // R3: with mono addressing, the mono index port is live
    a_r3_mono_live: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !q.misc[0] && addr == ADDR_W'(P_CRTC_IDX ^ P_FOLD))
        |=> (crtc_idx == $past(wdata[CIDX_W-1:0])));

endmodule

// File: tb/vga_host_regs_bench.sv
module vga_host_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [15:0] win_off;
    logic [18:0] bank_base;
    logic [18:0] fb_addr;
    logic        timing_chg;

    always #5 clk = ~clk;

    vga_host_regs u_vga_host_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .win_off    (win_off),
        .bank_base  (bank_base),
        .fb_addr    (fb_addr),
        .timing_chg (timing_chg)
    );

    int compared   = 0;
    int mismatched = 0;
    bit done       = 0;

    // reference model state
    int m_crtc[32];
    int m_idx, m_misc, m_mode, m_bank, m_ext, m_base;
    int m_chg;

    function automatic void m_reset();
        foreach (m_crtc[i]) m_crtc[i] = 0;
        m_idx = 0; m_misc = 1; m_mode = 0; m_bank = 0; m_ext = 0; m_base = 0; m_chg = 0;
    endfunction

    function automatic int m_eff(int a);
        if ((m_misc % 2) == 0 && ((a / 16) == 'h3D || (a / 16) == 'h3B)) return a ^ 'h60;
        return a;
    endfunction

    function automatic int m_read(int a);
        case (m_eff(a))
            'h3CC:   return m_misc;
            'h3D4:   return m_idx;
            'h3D5:   return m_crtc[m_idx];
            'h2108:  return m_bank;
            'h210A:  return m_ext;
            'h100:   return 'hFE;
            'h101:   return 'hE8;
            default: return 'hFF;
        endcase
    endfunction

    function automatic void m_write(int a, int v);
        int nv;
        int locked;
        m_chg = 0;
        locked = (m_crtc['h11] >= 'h80);
        case (m_eff(a))
            'h3C2: m_misc = v;
            'h3D4: m_idx = v % 32;
            'h3D5: begin
                if (!(locked && m_idx <= 6)) begin
                    if (locked && m_idx == 7) nv = (m_crtc[7] & 'hEF) | (v & 'h10);
                    else nv = v;
                    if (nv != m_crtc[m_idx] && (m_idx < 'h0E || m_idx > 'h10)) m_chg = 1;
                    m_crtc[m_idx] = nv;
                end
            end
            'h2100: begin
                m_mode = v % 8;
                m_base = (m_mode < 4) ? 0 : (m_bank % 8) * 'h10000;
            end
            'h2108: begin
                m_bank = v;
                if (m_mode >= 4) m_base = (v % 8) * 'h10000;
            end
            'h210A: m_ext = v;
            default: ;
        endcase
    endfunction

    function automatic string tag_of(int a);
        case (a)
            'h3D4:                 return "R2";
            'h3D5:                 return "R4";
            'h3B4, 'h3B5:          return "R3";
            'h2100:                return "R7";
            'h2108:                return "R8";
            default:               return "R9";
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // one clock: drive at negedge, check comb read, then registered outputs at next negedge
    task automatic cyc(bit we, int a, int v, int w, string rtag);
        wr_en   = we;
        addr    = a[15:0];
        wdata   = v[7:0];
        win_off = w[15:0];
        #1;
        check(rtag, "rdata", int'(rdata), m_read(a));
        @(posedge clk);
        if (we) m_write(a, v);
        else    m_chg = 0;
        @(negedge clk);
        check("R6", "timing_chg", int'(timing_chg), m_chg);
        check("R7", "bank_base", int'(bank_base), m_base);
        check("R10", "fb_addr", int'(fb_addr), (m_base + w) % 'h80000);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog (all requirements): actual running expected finished");
            summary();
            $finish;
        end
    end

    int pool[12] = '{'h3D4, 'h3D5, 'h3B4, 'h3B5, 'h3C2, 'h3CC,
                     'h2100, 'h2108, 'h210A, 'h100, 'h101, 'h2104};

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; win_off = '0;
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cyc(0, 'h3CC, 0, 0, "R1");
        cyc(0, 'h3D5, 0, 'h1234, "R1");
        cyc(0, 'h2108, 0, 0, "R1");
        // R2 index width
        cyc(1, 'h3D4, 'h25, 0, "R2");
        cyc(0, 'h3D4, 0, 0, "R2");
        // R6 change vs repeat vs quiet range
        cyc(1, 'h3D4, 2, 0, "R2");
        cyc(1, 'h3D5, 'h5A, 0, "R6");
        cyc(1, 'h3D5, 'h5A, 0, "R6");
        cyc(1, 'h3D4, 'h0F, 0, "R2");
        cyc(1, 'h3D5, 'h33, 0, "R6");
        cyc(0, 'h3D5, 0, 0, "R6");
        // R4 / R5 protection
        cyc(1, 'h3D4, 'h11, 0, "R2");
        cyc(1, 'h3D5, 'h80, 0, "R4");
        cyc(1, 'h3D4, 3, 0, "R2");
        cyc(1, 'h3D5, 'h77, 0, "R4");
        cyc(0, 'h3D5, 0, 0, "R4");
        cyc(1, 'h3D4, 7, 0, "R2");
        cyc(1, 'h3D5, 'hFF, 0, "R5");
        cyc(0, 'h3D5, 0, 0, "R5");
        cyc(1, 'h3D5, 'h00, 0, "R5");
        // R7 / R8 banking
        cyc(1, 'h2108, 5, 'h00FF, "R8");
        cyc(0, 'h2108, 0, 0, "R9");
        cyc(1, 'h2100, 4, 'hFFFF, "R7");
        cyc(1, 'h2108, 'hFA, 'h8000, "R8");
        cyc(1, 'h2100, 3, 'h0010, "R7");
        cyc(1, 'h2108, 'h07, 0, "R8");
        cyc(1, 'h2100, 'h0E, 'hFFFF, "R7");
        cyc(0, 'h2104, 0, 'h0001, "R10");
        // R9 fixed ID and readback
        cyc(1, 'h210A, 'hC3, 0, "R9");
        cyc(0, 'h210A, 0, 0, "R9");
        cyc(0, 'h100, 0, 0, "R9");
        cyc(0, 'h101, 0, 0, "R9");
        cyc(0, 'h2100, 0, 0, "R9");
        // R3 mono folding
        cyc(1, 'h3C2, 'h66, 0, "R3");
        cyc(0, 'h3CC, 0, 0, "R3");
        cyc(1, 'h3B4, 2, 0, "R3");
        cyc(0, 'h3B5, 0, 0, "R3");
        cyc(1, 'h3D4, 9, 0, "R3");
        cyc(0, 'h3D4, 0, 0, "R3");
        cyc(0, 'h3B4, 0, 0, "R3");
        cyc(1, 'h3D5, 'h11, 0, "R3");
        cyc(0, 'h3B5, 0, 0, "R3");
        cyc(1, 'h3C2, 'h01, 0, "R3");

        // random mixed traffic
        for (int n = 0; n < 3000; n++) begin
            int a;
            a = pool[$urandom_range(0, 11)];
            cyc(1'($urandom_range(0, 1)), a, int'($urandom_range(0, 255)),
                int'($urandom_range(0, 'hFFFF)), tag_of(a));
        end

        done = 1;
        summary();
        $finish;
    end

endmodule